// File: doc/BRIEF.md
# Lockable Two-Way Cache Controller

This block is a small two-way set-associative cache that sits between a processor's load/store port and a slower backing memory. Embedded software can pin part of its contents so that time-critical code and data see predictable, RAM-like access times. Writes go through to memory at once and a write miss does not allocate. A read miss refills a whole 8-word line, one word per memory handshake, in ascending order from the line base.

Two pinning mechanisms are provided. A per-way lock mask removes ways from victim choice and may be changed at any moment. A set-lock switch folds the index so that only the lower half of the sets is used, which keeps the upper half out of use. Because folding changes the address-to-set mapping, a switch change is applied only at the end of a full invalidation sweep. An explicit flush request runs the same sweep. Lines are preloaded into a way by reading them while that way is unlocked and then setting its lock bit.

All addresses are word addresses. With the default geometry (8 KB, 32-byte lines, 32-bit words) there are 128 sets: bits [2:0] select the word, bits [9:3] the set, and bits [13:9] form the stored tag. Bit 9 is carried in the tag so that the folded mapping stays unambiguous.

Top module: `lockable_cache`

## Requirements
- R1: A read that hits raises `rsp_valid` with the word in the cycle after acceptance and makes no memory access. Locked lines hit exactly like unlocked ones.
- R2: A read miss that may allocate fetches the 8 words of the line from the line base in ascending word order. `req_ready` stays low until the fill is done, and the requested word is returned 9 cycles after acceptance (with a memory that acknowledges every cycle). Later reads of that line hit.
- R3: Every write performs exactly one memory write of `req_wdata` to `req_addr`. A write hit also updates the cached word. A write miss does not allocate, so a later read of that line misses.
- R4: With no locks, a miss fills an invalid way first (way 0 before way 1). Otherwise it fills the least recently used way, tracked by one bit per set that is updated on every hit and fill.
- R5: A way whose `way_lock` bit is 1 is never chosen for a refill. A change of `way_lock` takes effect at once, with no flush and no loss of `req_ready`.
- R6: When both `way_lock` bits are 1, a read miss is served by a single memory read at the requested address, 2 cycles after acceptance, with no allocation. Repeating the read misses again.
- R7: A one-cycle `flush_req` pulse invalidates every line. `flush_busy` is then high for exactly 128 cycles (one set per cycle). During that time `req_ready`, `rsp_valid` and `mem_req` are all low.
- R8: When `set_lock_en` differs from the mode in force, a full sweep as in R7 runs and the new mode applies at its end. While set lock is on, set-index bit 9 is treated as 0, so two addresses that differ only in bit 9 compete for the same set.
- R9: After reset `req_ready` is 1, `rsp_valid`, `mem_req` and `flush_busy` are 0, every line is invalid and set lock is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Request is accepted on this edge when high |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | 32 | Read data (zero for writes) |
| way_lock | input | 2 | Per-way lock mask, bit w pins way w |
| set_lock_en | input | 1 | Requested set-lock mode |
| flush_req | input | 1 | Invalidate all lines |
| flush_busy | output | 1 | Invalidation sweep in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 14 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory completes the access this cycle |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |

## Verification
A corrupted valid bit, tag or LRU bit does not show as wrong data: the bad line is refetched through the write-through path. It shows instead as a change in memory traffic and latency on the very next access to that set: 8 reads and a 9-cycle response where 0 reads and 1 cycle were expected, or the reverse. The bench therefore counts memory reads and writes and measures latency on every access, using eviction orders chosen so that a wrong victim changes the count within one or two requests. A stale set-lock mode shows in the same way, as an extra refill on a pair of addresses that differ only in the folded bit.

// File: rtl/cache_pkg.sv
// Shared definitions for the lockable two-way cache.
// Assumes exactly two ways; the way index is therefore a single bit.
package cache_pkg;
    localparam int NWAYS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_SINGLE,
        ST_WRITE,
        ST_SWEEP
    } cache_state_t;
endpackage

// File: rtl/cache_tag_store.sv
// Valid bits, tags and one replacement bit per set for a two-way cache.
// Reads are combinational; valid and LRU bits reset synchronously, tags do not.
// Assumes the caller never issues clear and fill to the same set in one cycle.
module cache_tag_store #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7,
    parameter int TAG_W = 5
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [IDX_W-1:0]                      rd_idx,
    output logic [cache_pkg::NWAYS-1:0]           rd_valid,
    output logic [cache_pkg::NWAYS-1:0][TAG_W-1:0] rd_tag,
    output logic                                  rd_lru,
    input  logic                                  wr_en,
    input  logic                                  wr_way,
    input  logic [IDX_W-1:0]                      wr_idx,
    input  logic [TAG_W-1:0]                      wr_tag,
    input  logic                                  lru_en,
    input  logic [IDX_W-1:0]                      lru_idx,
    input  logic                                  lru_next,
    input  logic                                  clr_en,
    input  logic [IDX_W-1:0]                      clr_idx
);
    logic [cache_pkg::NWAYS-1:0] vld [SETS];
    logic                        lru [SETS];
    logic [TAG_W-1:0]            tag_mem [cache_pkg::NWAYS][SETS];

    // Valid and LRU state: reset, sweep clear, fill set and LRU update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                vld[s] <= '0;
                lru[s] <= 1'b0;
            end
        end else begin
            if (clr_en) vld[clr_idx] <= '0;
            if (wr_en) vld[wr_idx][wr_way] <= 1'b1;
            if (lru_en) lru[lru_idx] <= lru_next;
        end
    end

    // Tag storage, written at the end of a line fill.
    always_ff @(posedge clk) begin
        if (wr_en) tag_mem[wr_way][wr_idx] <= wr_tag;
    end

    for (genvar w = 0; w < cache_pkg::NWAYS; w++) begin : g_rd
        assign rd_valid[w] = vld[rd_idx][w];
        assign rd_tag[w]   = tag_mem[w][rd_idx];
    end

    assign rd_lru = lru[rd_idx];
endmodule

// File: rtl/cache_data_store.sv
// Line data for both ways, addressed by {set, word}. One write port,
// combinational read of the same word in every way.
module cache_data_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1024,
    parameter int AW     = 10
) (
    input  logic                                   clk,
    input  logic [AW-1:0]                          rd_addr,
    output logic [cache_pkg::NWAYS-1:0][DATA_W-1:0] rd_data,
    input  logic                                   wr_en,
    input  logic                                   wr_way,
    input  logic [AW-1:0]                          wr_addr,
    input  logic [DATA_W-1:0]                      wr_data
);
    logic [DATA_W-1:0] words [cache_pkg::NWAYS][DEPTH];

    // Single write port shared by write hits and refill beats.
    always_ff @(posedge clk) begin
        if (wr_en) words[wr_way][wr_addr] <= wr_data;
    end

    for (genvar w = 0; w < cache_pkg::NWAYS; w++) begin : g_rd
        assign rd_data[w] = words[w][rd_addr];
    end
endmodule

// File: rtl/cache_victim_sel.sv
// Picks the refill way for a two-way set. Locked ways are excluded; with
// both free an invalid way wins (way 0 first), else the LRU way. When both
// ways are locked no allocation is made.
module cache_victim_sel (
    input  logic [cache_pkg::NWAYS-1:0] valid,
    input  logic                        lru,
    input  logic [cache_pkg::NWAYS-1:0] lock,
    output logic                        way,
    output logic                        alloc
);
    // Victim decision by lock mask, then validity, then LRU.
    always_comb begin
        alloc = 1'b1;
        way   = 1'b0;
        unique case (lock)
            2'b11: alloc = 1'b0;
            2'b01: way = 1'b1;
            2'b10: way = 1'b0;
            default: begin
                if (!valid[0])      way = 1'b0;
                else if (!valid[1]) way = 1'b1;
                else                way = lru;
            end
        endcase
    end
endmodule

// File: rtl/lockable_cache.sv
// Two-way write-through cache with per-way and half-array set locking.
// Assumes word addressing, a power-of-two geometry and a memory that holds
// each request until mem_ack. Set-lock mode changes only at the end of a sweep.
module lockable_cache #(
    parameter int ADDR_W     = 14,
    parameter int DATA_W     = 32,
    parameter int CAPACITY   = 8192,
    parameter int LINE_BYTES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic [1:0]        way_lock,
    input  logic              set_lock_en,
    input  logic              flush_req,
    output logic              flush_busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata
);
    import cache_pkg::*;

    localparam int WORDS  = LINE_BYTES / (DATA_W / 8);
    localparam int SETS   = CAPACITY / LINE_BYTES / NWAYS;
    localparam int WOFF_W = $clog2(WORDS);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - WOFF_W - IDX_W + 1;
    localparam int DAW    = IDX_W + WOFF_W;
    localparam logic [WOFF_W-1:0] LAST_BEAT = '1;
    localparam logic [IDX_W-1:0]  LAST_SET  = '1;

    cache_state_t      state;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic              way_q;
    logic [WOFF_W-1:0] beat_q;
    logic [IDX_W-1:0]  sweep_idx;
    logic              set_lock_act;

    logic [IDX_W-1:0]  raw_idx, lk_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WOFF_W-1:0] req_woff;
    logic [NWAYS-1:0]  rd_valid, hit_vec;
    logic [NWAYS-1:0][TAG_W-1:0]  rd_tag;
    logic [NWAYS-1:0][DATA_W-1:0] rd_word;
    logic              rd_lru, hit, hit_way, vic_way, vic_alloc;
    logic              sweep_pend, accept, fill_commit;
    logic              tag_lru_en, tag_lru_next;
    logic [IDX_W-1:0]  tag_lru_idx;
    logic              dat_we, dat_way;
    logic [DAW-1:0]    dat_waddr;
    logic [DATA_W-1:0] dat_wdata;

    // Address split; set lock folds the top index bit to zero.
    always_comb begin
        raw_idx  = req_addr[WOFF_W +: IDX_W];
        lk_idx   = set_lock_act ? {1'b0, raw_idx[IDX_W-2:0]} : raw_idx;
        req_tag  = req_addr[ADDR_W-1 -: TAG_W];
        req_woff = req_addr[WOFF_W-1:0];
    end

    cache_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_lru(rd_lru),
        .wr_en(fill_commit), .wr_way(way_q), .wr_idx(idx_q), .wr_tag(tag_q),
        .lru_en(tag_lru_en), .lru_idx(tag_lru_idx), .lru_next(tag_lru_next),
        .clr_en(flush_busy), .clr_idx(sweep_idx)
    );

    cache_data_store #(.DATA_W(DATA_W), .DEPTH(SETS * WORDS), .AW(DAW)) u_data (
        .clk(clk), .rd_addr({lk_idx, req_woff}), .rd_data(rd_word),
        .wr_en(dat_we), .wr_way(dat_way), .wr_addr(dat_waddr), .wr_data(dat_wdata)
    );

    cache_victim_sel u_victim (
        .valid(rd_valid), .lru(rd_lru), .lock(way_lock),
        .way(vic_way), .alloc(vic_alloc)
    );

    for (genvar w = 0; w < NWAYS; w++) begin : g_hit
        assign hit_vec[w] = rd_valid[w] && (rd_tag[w] == req_tag);
    end

    assign hit        = |hit_vec;
    assign hit_way    = hit_vec[1];
    assign sweep_pend = flush_req || (set_lock_en != set_lock_act);
    assign req_ready  = (state == ST_IDLE) && !sweep_pend;
    assign accept     = req_valid && req_ready;
    assign fill_commit = (state == ST_FILL) && mem_ack && (beat_q == LAST_BEAT);
    assign flush_busy = (state == ST_SWEEP);

    // LRU update: any accepted hit, or the end of a refill.
    always_comb begin
        tag_lru_en   = 1'b0;
        tag_lru_idx  = lk_idx;
        tag_lru_next = ~hit_way;
        if (accept && hit) begin
            tag_lru_en = 1'b1;
        end else if (fill_commit) begin
            tag_lru_en   = 1'b1;
            tag_lru_idx  = idx_q;
            tag_lru_next = ~way_q;
        end
    end

    // Data write source: write hit in idle, or a refill beat.
    always_comb begin
        dat_we    = 1'b0;
        dat_way   = hit_way;
        dat_waddr = {lk_idx, req_woff};
        dat_wdata = req_wdata;
        if (accept && req_write && hit) begin
            dat_we = 1'b1;
        end else if (state == ST_FILL && mem_ack) begin
            dat_we    = 1'b1;
            dat_way   = way_q;
            dat_waddr = {idx_q, beat_q};
            dat_wdata = mem_rdata;
        end
    end

    // Memory request signals derived from the current state.
    always_comb begin
        mem_req   = (state == ST_FILL) || (state == ST_SINGLE) || (state == ST_WRITE);
        mem_we    = (state == ST_WRITE);
        mem_wdata = d_q;
        mem_addr  = a_q;
        if (state == ST_FILL) mem_addr = {a_q[ADDR_W-1:WOFF_W], beat_q};
    end

    // Control sequencer: lookup, refill, uncached read, write-through, sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            a_q          <= '0;
            d_q          <= '0;
            idx_q        <= '0;
            tag_q        <= '0;
            way_q        <= 1'b0;
            beat_q       <= '0;
            sweep_idx    <= '0;
            set_lock_act <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (sweep_pend) begin
                        state     <= ST_SWEEP;
                        sweep_idx <= '0;
                    end else if (req_valid) begin
                        a_q    <= req_addr;
                        d_q    <= req_wdata;
                        idx_q  <= lk_idx;
                        tag_q  <= req_tag;
                        way_q  <= vic_way;
                        beat_q <= '0;
                        if (req_write) begin
                            state <= ST_WRITE;
                        end else if (hit) begin
                            rsp_valid <= 1'b1;
                            rsp_rdata <= rd_word[hit_way];
                        end else if (vic_alloc) begin
                            state <= ST_FILL;
                        end else begin
                            state <= ST_SINGLE;
                        end
                    end
                end
                ST_FILL: begin
                    if (mem_ack) begin
                        beat_q <= beat_q + 1'b1;
                        if (beat_q == a_q[WOFF_W-1:0]) rsp_rdata <= mem_rdata;
                        if (beat_q == LAST_BEAT) begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                        end
                    end
                end
                ST_SINGLE: begin
                    if (mem_ack) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= mem_rdata;
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        state     <= ST_IDLE;
                        rsp_valid <= 1'b1;
                        rsp_rdata <= '0;
                    end
                end
                ST_SWEEP: begin
                    sweep_idx <= sweep_idx + 1'b1;
                    if (sweep_idx == LAST_SET) begin
                        state        <= ST_IDLE;
                        set_lock_act <= set_lock_en;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lockable_cache_chk.sv
// Protocol and locking checks for lockable_cache, attached by bind.
module lockable_cache_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              flush_busy,
    input logic [1:0]        way_lock,
    input logic              fill_commit,
    input logic              fill_way,
    input logic              set_lock_act
);
    // R7
    sweep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_busy |-> (!req_ready && !mem_req && !rsp_valid));

    // R2
    mem_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready);

    // R2
    fill_ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack && $past(mem_req && !mem_we && mem_ack))
        |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R3
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=> (mem_req && mem_we && $stable(mem_addr)));

    // R5
    locked_way_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_commit |-> !way_lock[fill_way]);

    // R8
    set_mode_at_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(set_lock_act) |-> $past(flush_busy));
endmodule

bind lockable_cache lockable_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .flush_busy(flush_busy), .way_lock(way_lock), .fill_commit(fill_commit),
    .fill_way(way_q), .set_lock_act(set_lock_act)
);

// File: tb/lockable_cache_test.sv
`timescale 1ns/1ps
module lockable_cache_test;
    localparam int AW = 14;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic req_ready, rsp_valid, flush_busy, mem_req, mem_we, mem_ack;
    logic [DW-1:0] rsp_rdata, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [1:0] way_lock = 2'b00;
    logic set_lock_en = 1'b0, flush_req = 1'b0;

    int n_chk = 0, n_err = 0;
    int rd_cnt = 0, wr_cnt = 0;
    bit finished = 1'b0;
    logic [DW-1:0] model [1 << AW];

    always #2.5 clk = ~clk;

    lockable_cache uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .way_lock(way_lock),
        .set_lock_en(set_lock_en), .flush_req(flush_req), .flush_busy(flush_busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // Zero-wait backing memory with access counters.
    assign mem_ack   = mem_req;
    assign mem_rdata = model[mem_addr];
    always @(posedge clk) begin
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                model[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end else begin
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // One request; returns read data, memory reads/writes and latency.
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output int nrd, output int nwr,
                          output int lat);
        int r0, w0;
        while (!req_ready) @(negedge clk);
        r0 = rd_cnt; w0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid) begin
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        nrd = rd_cnt - r0;
        nwr = wr_cnt - w0;
        @(negedge clk);
    endtask

    task automatic read_expect(input string tag, input logic [AW-1:0] a, input int exp_rd);
        logic [DW-1:0] rd;
        int nrd, nwr, lat;
        access(1'b0, a, '0, rd, nrd, nwr, lat);
        check(tag, "read data", rd, model[a]);
        check(tag, "memory reads", nrd, exp_rd);
    endtask

    task automatic sweep_len(input string tag, output int n);
        n = 0;
        while (flush_busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
        check(tag, "ready after sweep", {31'b0, req_ready}, 32'd1);
    endtask

    typedef struct packed {
        logic        wr;
        logic [13:0] addr;
        logic [31:0] wdata;
        logic [3:0]  nrd;
        logic [1:0]  nwr;
    } vec_t;

    // Set 3 and set 4 traffic, no locks (word address = tag<<10 | set<<3 | word).
    localparam vec_t VECS [12] = '{
        '{1'b0, 14'h019, 32'h0, 4'd8, 2'd0},        // R2 cold miss, word 1
        '{1'b0, 14'h01E, 32'h0, 4'd0, 2'd0},        // R1 same line hits
        '{1'b0, 14'h418, 32'h0, 4'd8, 2'd0},        // R4 invalid way 1 filled
        '{1'b0, 14'h018, 32'h0, 4'd0, 2'd0},        // R1 way 0 still there
        '{1'b0, 14'h818, 32'h0, 4'd8, 2'd0},        // R4 evicts LRU way 1
        '{1'b0, 14'h018, 32'h0, 4'd0, 2'd0},        // R4 way 0 kept
        '{1'b0, 14'h418, 32'h0, 4'd8, 2'd0},        // R4 refill way 1
        '{1'b0, 14'h818, 32'h0, 4'd8, 2'd0},        // R4 now evicts way 0
        '{1'b1, 14'h41A, 32'hCAFE0001, 4'd0, 2'd1}, // R3 write hit
        '{1'b0, 14'h41A, 32'h0, 4'd0, 2'd0},        // R3 cached copy updated
        '{1'b1, 14'hC21, 32'hBEEF0002, 4'd0, 2'd1}, // R3 write miss
        '{1'b0, 14'hC21, 32'h0, 4'd8, 2'd0}         // R3 no allocation on write
    };

    initial begin
        logic [DW-1:0] rd;
        int nrd, nwr, lat, n;
        for (int i = 0; i < (1 << AW); i++) model[i] = i * 32'h9E3779B1 + 32'h1234;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        check("R9", "req_ready", {31'b0, req_ready}, 32'd1);
        check("R9", "rsp_valid", {31'b0, rsp_valid}, 32'd0);
        check("R9", "mem_req", {31'b0, mem_req}, 32'd0);
        check("R9", "flush_busy", {31'b0, flush_busy}, 32'd0);

        for (int v = 0; v < 12; v++) begin
            access(VECS[v].wr, VECS[v].addr, VECS[v].wdata, rd, nrd, nwr, lat);
            if (!VECS[v].wr) check("R1..R4 table", "read data", rd, model[VECS[v].addr]);
            check("R1..R4 table", "memory reads", nrd, {28'b0, VECS[v].nrd});
            check("R1..R4 table", "memory writes", nwr, {30'b0, VECS[v].nwr});
            if (!VECS[v].wr && VECS[v].nrd == 0) check("R1", "hit latency", lat, 1);
            if (!VECS[v].wr && VECS[v].nrd == 8) check("R2", "fill latency", lat, 9);
            if (VECS[v].wr) check("R3", "written word in memory", model[VECS[v].addr], VECS[v].wdata);
        end

        // R7 flush sweep
        flush_req = 1'b1;
        #1;
        check("R7", "ready during flush request", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        flush_req = 1'b0;
        sweep_len("R7", n);
        check("R7", "sweep cycles", n, 128);
        read_expect("R7", 14'h41A, 8);

        // R5 way locking in set 10
        read_expect("R5", 14'h050, 8);
        read_expect("R5", 14'h450, 8);
        way_lock = 2'b01;
        @(negedge clk);
        check("R5", "no sweep on lock change", {31'b0, flush_busy}, 32'd0);
        check("R5", "ready kept on lock change", {31'b0, req_ready}, 32'd1);
        read_expect("R5", 14'h050, 0);
        read_expect("R5", 14'h850, 8);
        read_expect("R5", 14'hC50, 8);
        read_expect("R5", 14'h050, 0);

        // R6 both ways locked
        way_lock = 2'b11;
        access(1'b0, 14'h1050, '0, rd, nrd, nwr, lat);
        check("R6", "uncached data", rd, model[14'h1050]);
        check("R6", "single read", nrd, 1);
        check("R6", "uncached latency", lat, 2);
        read_expect("R6", 14'h1050, 1);
        read_expect("R6", 14'hC50, 0);
        way_lock = 2'b00;

        // R8 set lock on: bit 9 folded, so 0x028/0x228/0x628 share set 5
        set_lock_en = 1'b1;
        #1;
        check("R8", "ready held for mode change", {31'b0, req_ready}, 32'd0);
        @(negedge clk);
        sweep_len("R8", n);
        check("R8", "sweep cycles on enable", n, 128);
        read_expect("R8", 14'h028, 8);
        read_expect("R8", 14'h228, 8);
        read_expect("R8", 14'h628, 8);
        read_expect("R8", 14'h028, 8);

        // R8 set lock off: the same pattern uses two sets
        set_lock_en = 1'b0;
        @(negedge clk);
        sweep_len("R8", n);
        check("R8", "sweep cycles on disable", n, 128);
        read_expect("R8", 14'h028, 8);
        read_expect("R8", 14'h228, 8);
        read_expect("R8", 14'h628, 8);
        read_expect("R8", 14'h028, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule